// File: doc/BRIEF.md
# T1 to Backplane Output Formatter

This block is the system-side read sequencer of a receive elastic store. It places buffered 193-bit T1 frames onto a serial backplane that runs either at the T1 rate (193 bit times per frame) or at the 2.048 MHz rate (256 bit times, 32 eight-bit channels). For each system clock cycle it decides whether the elastic store is read, through a read strobe, and what goes out on the serial line. The output is either the bit the store presents in that cycle or a filler one.

A rising edge on the system frame sync aligns the bit counter. In T1-rate mode the frame bit is read and sent first, followed by the 192 payload bits. In 2.048 MHz mode the frame-bit slot is dropped and sent as a one. Channel 1's most significant bit follows in the next bit time, and every slot after channel 24 is filled with ones. In parallel mode the data timeline runs 8 bit times ahead of the frame sync, so that an external serial-to-parallel converter can produce a byte on the sync boundary. A frame counter of modulo 12 issues a 65-cycle multiframe pulse at the start of frame 0.

Two small state machines control the block. The sequencer has the states SEQ_WAIT and SEQ_RUN. Its transition "first sync" goes from SEQ_WAIT to SEQ_RUN on the first frame-sync rise after reset. In SEQ_RUN two self-transitions restart the frame: "wrap" at the last bit time, and "resync" on any later frame-sync rise. The multiframe machine has the states MF_LOW and MF_HIGH. Its transition "mf start" goes from either state to MF_HIGH when frame 0 begins. Its transition "mf expire" goes from MF_HIGH to MF_LOW when the hold count runs out.

Top module: `t1bp_formatter`

## Requirements
- R1: After reset and until the first rising edge of `sys_fsync` is sampled, `line_out` is 1, `store_rd` is 0 and `mfrm_pulse` is 0.
- R2: When a rising edge of `sys_fsync` (high now, low at the previous edge) is sampled at a clock edge, the cycle that follows is bit time 0 of a new frame. This holds whatever the bit position was before.
- R3: With `wide_sel`=0 a frame is 193 cycles. In every cycle `store_rd` is 1 and `line_out` equals `store_bit`, so the frame bit is read and sent in slot 0.
- R4: With `wide_sel`=1 a frame is 256 cycles. Slot 0 is the dropped frame-bit slot: `line_out` is 1 and `store_rd` is 0.
- R5: With `wide_sel`=1, slots 1 to 192 carry channels 1 to 24, with the most significant bit first. In these slots `store_rd` is 1 and `line_out` equals `store_bit`.
- R6: With `wide_sel`=1, slots 193 to 255 (channels 25 to 32) are filled: `line_out` is 1 and `store_rd` is 0.
- R7: With `serial_sel`=1, the data slot in cycle k of a frame is k. With `serial_sel`=0 (parallel), it is (k+8) mod frame length.
- R8: Without a frame sync the frame counter wraps by itself after 193 or 256 cycles. The next frame starts at bit time 0.
- R9: Frames are numbered modulo 12. The first frame after the first sync is frame 0, and each wrap or resync begins the next number.
- R10: `mfrm_pulse` is high for exactly the first 65 cycles of every frame numbered 0 and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System backplane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_fsync | input | 1 | System frame sync; its rising edge aligns the frame |
| wide_sel | input | 1 | 0: 193-bit frame with frame bit; 1: 256-bit frame, frame bit dropped |
| serial_sel | input | 1 | 1: serial timing; 0: parallel timing, data 8 bit times early |
| store_bit | input | 1 | Bit presented by the elastic store in the current cycle |
| line_out | output | 1 | Serial backplane data |
| store_rd | output | 1 | Read strobe to the elastic store |
| mfrm_pulse | output | 1 | System multiframe boundary pulse |

## Verification
A wrong bit position shows at once as a misplaced band of ones or a misplaced read strobe. In 2.048 MHz mode the dropped-bit slot and the 63 filled slots have fixed positions, so even a one-count offset is visible within one frame. A wrong frame number only shows when the multiframe pulse appears in the wrong frame, which can take up to 12 frames. For this reason the sweeps run 13 frames in every mode, and a mid-frame resync checks that the counters restart on the very next cycle.

// File: rtl/t1bp_pkg.sv
package t1bp_pkg;

    // Sequencer states
    typedef enum logic {
        SEQ_WAIT = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Multiframe pulse states
    typedef enum logic {
        MF_LOW  = 1'b0,
        MF_HIGH = 1'b1
    } mf_state_t;

    // What a given output slot carries
    typedef enum logic [2:0] {
        SLOT_OFF   = 3'd0,
        SLOT_FPASS = 3'd1,
        SLOT_FDROP = 3'd2,
        SLOT_DATA  = 3'd3,
        SLOT_FILL  = 3'd4
    } slot_kind_t;

endpackage

// File: rtl/t1bp_seq.sv
module t1bp_seq
    import t1bp_pkg::*;
#(
    parameter int unsigned T1_LEN    = 193,
    parameter int unsigned E1_LEN    = 256,
    parameter int unsigned CW        = 8,
    parameter int unsigned MF_FRAMES = 12,
    parameter int unsigned FW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_fsync,
    input  logic          wide_mode,
    output logic          running,
    output logic [CW-1:0] bit_pos,
    output logic [FW-1:0] frame_idx,
    output logic          mf_start
);

    seq_state_t    st_q, st_d;
    logic          fsync_q;
    logic          rise;
    logic          at_end;
    logic          restart;
    logic [CW-1:0] last_pos;
    logic          idx_last;

    assign rise     = sys_fsync & ~fsync_q;
    assign last_pos = wide_mode ? CW'(E1_LEN - 1) : CW'(T1_LEN - 1);
    assign at_end   = (bit_pos >= last_pos);
    assign idx_last = (frame_idx == FW'(MF_FRAMES - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and frame-start decisions
    always_comb begin
        st_d     = st_q;
        restart  = 1'b0;
        mf_start = 1'b0;
        unique case (st_q)
            SEQ_WAIT: begin
                if (rise) begin          // first sync
                    st_d     = SEQ_RUN;
                    restart  = 1'b1;
                    mf_start = 1'b1;
                end
            end
            SEQ_RUN: begin
                restart  = rise | at_end; // resync or wrap
                mf_start = restart & idx_last;
            end
            default: begin
                st_d = SEQ_WAIT;
            end
        endcase
    end

    // Bit and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_q   <= 1'b0;
            bit_pos   <= '0;
            frame_idx <= '0;
        end else begin
            fsync_q <= sys_fsync;
            if (restart) begin
                bit_pos <= '0;
                if (st_q == SEQ_WAIT || idx_last) begin
                    frame_idx <= '0;
                end else begin
                    frame_idx <= frame_idx + FW'(1);
                end
            end else if (st_q == SEQ_RUN) begin
                bit_pos <= bit_pos + CW'(1);
            end
        end
    end

    assign running = (st_q == SEQ_RUN);

    // R2
    sync_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_fsync && !fsync_q) |=> (bit_pos == '0 && running));

    // R8
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (bit_pos <= last_pos || $past(wide_mode) != wide_mode));

    // R9
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx < FW'(MF_FRAMES));

endmodule

// File: rtl/t1bp_mf.sv
module t1bp_mf
    import t1bp_pkg::*;
#(
    parameter int unsigned MF_HOLD = 65,
    parameter int unsigned MW      = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mf_start,
    output logic mf_pulse
);

    mf_state_t     st_q, st_d;
    logic [MW-1:0] hold_q;
    logic          hold_done;

    assign hold_done = (hold_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= MF_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MF_LOW: begin
                if (mf_start) st_d = MF_HIGH;        // mf start
            end
            MF_HIGH: begin
                if (mf_start)       st_d = MF_HIGH;  // mf start again
                else if (hold_done) st_d = MF_LOW;   // mf expire
            end
            default: st_d = MF_LOW;
        endcase
    end

    // Hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (mf_start) begin
            hold_q <= MW'(MF_HOLD - 1);
        end else if (st_q == MF_HIGH && !hold_done) begin
            hold_q <= hold_q - MW'(1);
        end
    end

    assign mf_pulse = (st_q == MF_HIGH);

    // R10
    mf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_pulse) |-> $past(mf_start));

    // R10
    mf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mf_pulse) |-> !$past(mf_start));

endmodule

// File: rtl/t1bp_slot_fmt.sv
module t1bp_slot_fmt
    import t1bp_pkg::*;
#(
    parameter int unsigned T1_LEN   = 193,
    parameter int unsigned E1_LEN   = 256,
    parameter int unsigned CW       = 8,
    parameter int unsigned PAY_LAST = 192,
    parameter int unsigned PAR_LEAD = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic [CW-1:0] bit_pos,
    input  logic          wide_mode,
    input  logic          serial_mode,
    input  logic          store_bit,
    output logic          line_out,
    output logic          store_rd
);

    logic [CW:0]   frame_len;
    logic [CW-1:0] lead_pos;
    logic [CW-1:0] slot;
    slot_kind_t    kind;

    assign frame_len = wide_mode ? (CW+1)'(E1_LEN) : (CW+1)'(T1_LEN);

    generate
        if (PAR_LEAD > 0) begin : g_lead
            logic [CW:0] sum;
            assign sum      = {1'b0, bit_pos} + (CW+1)'(PAR_LEAD);
            assign lead_pos = (sum >= frame_len) ? CW'(sum - frame_len) : CW'(sum);
        end else begin : g_nolead
            assign lead_pos = bit_pos;
        end
    endgenerate

    assign slot = serial_mode ? bit_pos : lead_pos;

    // Classify the slot
    always_comb begin
        if (!running) begin
            kind = SLOT_OFF;
        end else if (slot == '0) begin
            kind = wide_mode ? SLOT_FDROP : SLOT_FPASS;
        end else if (!wide_mode || slot <= CW'(PAY_LAST)) begin
            kind = SLOT_DATA;
        end else begin
            kind = SLOT_FILL;
        end
    end

    // Outputs per slot kind
    always_comb begin
        line_out = 1'b1;
        store_rd = 1'b0;
        unique case (kind)
            SLOT_FPASS, SLOT_DATA: begin
                line_out = store_bit;
                store_rd = 1'b1;
            end
            SLOT_OFF, SLOT_FDROP, SLOT_FILL: begin
                line_out = 1'b1;
                store_rd = 1'b0;
            end
            default: begin
                line_out = 1'b1;
                store_rd = 1'b0;
            end
        endcase
    end

    // R1
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (line_out && !store_rd));

    // R6
    fill_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !store_rd |-> line_out);

    // R3
    narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wide_mode) |-> store_rd);

endmodule

// File: rtl/t1bp_formatter.sv
module t1bp_formatter
    import t1bp_pkg::*;
#(
    parameter int unsigned CH_BITS   = 8,
    parameter int unsigned T1_CH     = 24,
    parameter int unsigned E1_CH     = 32,
    parameter int unsigned MF_FRAMES = 12,
    parameter int unsigned MF_HOLD   = 65,
    parameter int unsigned PAR_LEAD  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_fsync,
    input  logic wide_sel,
    input  logic serial_sel,
    input  logic store_bit,
    output logic line_out,
    output logic store_rd,
    output logic mfrm_pulse
);

    localparam int unsigned PAY_LAST = T1_CH * CH_BITS;
    localparam int unsigned T1_LEN   = PAY_LAST + 1;
    localparam int unsigned E1_LEN   = E1_CH * CH_BITS;
    localparam int unsigned MAX_LEN  = (E1_LEN > T1_LEN) ? E1_LEN : T1_LEN;
    localparam int unsigned CW       = $clog2(MAX_LEN);
    localparam int unsigned FW       = $clog2(MF_FRAMES + 1);
    localparam int unsigned MW       = $clog2(MF_HOLD + 1);

    logic          running;
    logic [CW-1:0] bit_pos;
    logic [FW-1:0] frame_idx;
    logic          mf_start;

    t1bp_seq #(
        .T1_LEN   (T1_LEN),
        .E1_LEN   (E1_LEN),
        .CW       (CW),
        .MF_FRAMES(MF_FRAMES),
        .FW       (FW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_fsync(sys_fsync),
        .wide_mode(wide_sel),
        .running  (running),
        .bit_pos  (bit_pos),
        .frame_idx(frame_idx),
        .mf_start (mf_start)
    );

    t1bp_mf #(
        .MF_HOLD(MF_HOLD),
        .MW     (MW)
    ) u_mf (
        .clk     (clk),
        .rst_n   (rst_n),
        .mf_start(mf_start),
        .mf_pulse(mfrm_pulse)
    );

    t1bp_slot_fmt #(
        .T1_LEN  (T1_LEN),
        .E1_LEN  (E1_LEN),
        .CW      (CW),
        .PAY_LAST(PAY_LAST),
        .PAR_LEAD(PAR_LEAD)
    ) u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .bit_pos    (bit_pos),
        .wide_mode  (wide_sel),
        .serial_mode(serial_sel),
        .store_bit  (store_bit),
        .line_out   (line_out),
        .store_rd   (store_rd)
    );

    // R9
    mf_frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mfrm_pulse) |-> (frame_idx == '0 && bit_pos == '0));

endmodule

// File: tb/t1bp_formatter_test.sv
module t1bp_formatter_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_fsync = 1'b0;
    logic wide_sel = 1'b0;
    logic serial_sel = 1'b1;
    logic store_bit = 1'b0;
    logic line_out, store_rd, mfrm_pulse;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    t1bp_formatter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_fsync (sys_fsync),
        .wide_sel  (wide_sel),
        .serial_sel(serial_sel),
        .store_bit (store_bit),
        .line_out  (line_out),
        .store_rd  (store_rd),
        .mfrm_pulse(mfrm_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        sys_fsync = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    // R1: outputs stay quiet before the first sync
    task automatic idle_checks(input int n);
        for (int i = 0; i < n; i++) begin
            store_bit = i[0];
            @(negedge clk);
            chk(line_out == 1'b1, "R1", "idle line_out", line_out, 1);
            chk(store_rd == 1'b0, "R1", "idle store_rd", store_rd, 0);
            chk(mfrm_pulse == 1'b0, "R1", "idle mfrm_pulse", mfrm_pulse, 0);
            @(posedge clk); #2;
        end
    endtask

    task automatic run_mode(input bit wide, input bit serial, input int nframes,
                            input int resync_at);
        int  flen, k, fr, fidx, s;
        bit  d, exp_out, exp_rd, exp_mf, rs, periodic, by_sync, pay;
        string tag, mtag;
        flen = wide ? 256 : 193;
        wide_sel = wide;
        serial_sel = serial;
        do_reset();
        idle_checks(5);
        sys_fsync = 1'b1;
        @(posedge clk); #2;
        sys_fsync = 1'b0;
        k = 0; fr = 0; fidx = 0; by_sync = 1'b1;
        while (fr < nframes) begin
            d = ^(32'(k * 37 + fr * 11 + (wide ? 5 : 0) + (serial ? 0 : 3)));
            store_bit = d;
            rs = (fr == 0 && resync_at > 0 && k == resync_at - 1);
            periodic = (k == flen - 1) && (fr % 2 == 0);
            sys_fsync = rs || periodic;
            s = serial ? k : (k + 8) % flen;
            if (!wide) begin
                exp_rd = 1'b1; exp_out = d; tag = "R3";
            end else begin
                pay = (s >= 1 && s <= 192);
                exp_rd = pay;
                exp_out = pay ? d : 1'b1;
                tag = (s == 0) ? "R4" : (pay ? "R5" : "R6");
            end
            if (resync_at > 0 && fr == 1) tag = "R2";
            else if (!serial) tag = "R7";
            else if (!by_sync && fr > 0) tag = "R8";
            exp_mf = (fidx == 0) && (k < 65);
            mtag = (fr >= 12 || resync_at > 0) ? "R9" : "R10";
            @(negedge clk);
            chk(line_out == exp_out, tag, $sformatf("line_out fr=%0d k=%0d", fr, k),
                line_out, exp_out);
            chk(store_rd == exp_rd, tag, $sformatf("store_rd fr=%0d k=%0d", fr, k),
                store_rd, exp_rd);
            chk(mfrm_pulse == exp_mf, mtag, $sformatf("mfrm_pulse fr=%0d k=%0d", fr, k),
                mfrm_pulse, exp_mf);
            @(posedge clk); #2;
            if (rs || k == flen - 1) begin
                by_sync = rs || periodic;
                k = 0;
                fr++;
                fidx = (fidx + 1) % 12;
            end else begin
                k++;
            end
        end
        sys_fsync = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state with data toggling
        do_reset();
        idle_checks(20);
        run_mode(1'b0, 1'b1, 13, 0);   // R3 R8 R9 R10
        run_mode(1'b0, 1'b0, 13, 0);   // R7 narrow
        run_mode(1'b1, 1'b1, 13, 0);   // R4 R5 R6
        run_mode(1'b1, 1'b0, 13, 0);   // R7 wide
        run_mode(1'b1, 1'b1, 3, 100);  // R2 mid-frame resync
        run_mode(1'b0, 1'b0, 3, 150);  // R2 parallel resync
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule